// File: doc/BRIEF.md
# Pin Event Accumulator

This block counts transitions on one external input pin. The pin is first passed through a synchronizer chain. An edge detector then picks out the qualifying transitions, and an 8-bit counter advances once for each of them. Every counted event sets an edge flag. When the counter wraps from 255 to 0, an overflow flag is set as well.

Software reaches the block through a small register port with four addresses: count, control, flags and mask. Reads are combinational. A flag is cleared by writing 1 to its bit. Each flag drives its own interrupt line, and that line is active only while the matching mask bit is set.

The control register holds three bits. The first starts and stops counting. The second selects counting on both edges. The third selects rising or falling edges when single-edge counting is in force.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count, control, flag and mask registers read 0, and both interrupt outputs are low.
- R2: A pin level sampled at a rising clock edge that differs from the level sampled at the previous edge is counted at the second rising edge after the one that sampled it. This timing applies with the default two synchronizer stages.
- R3: While control bit 0 (enable) is 0, no event is counted and no flag is set.
- R4: With control bit 1 (mode) at 0, control bit 2 selects the counted edge: 1 counts rising edges only, 0 counts falling edges only.
- R5: With control bit 1 at 1, both rising and falling edges are counted, whatever the value of bit 2.
- R6: An event that arrives while the count is 255 makes the count 0 and sets the overflow flag, bit 5 of the flag register.
- R7: Every counted event sets the edge flag, bit 4 of the flag register.
- R8: A write to the flag register clears each flag whose bit position holds 1 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq_ovf` is high exactly when the overflow flag and mask bit 5 are both 1. `irq_edge` is high exactly when the edge flag and mask bit 4 are both 1.
- R10: A write to address 0 loads the count with the written data at the next edge. An event that falls in that same cycle is dropped: it neither counts nor sets a flag.
- R11: Address map: 0 is the count, 1 is control in bits [2:0], 2 is the flags, 3 is the mask. All unused bits read 0, and `rdata` follows `addr` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous event pin |
| addr | input | 2 | Register address |
| wr | input | 1 | Write strobe for the addressed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Edge interrupt request |

## Verification
The bench builds the block with its defaults: two synchronizer stages and an 8-bit count. The two-edge latency of R2 is therefore fixed and can be modelled exactly. Counter preloads through address 0 bring the 255-to-0 wrap within a few cycles. Pin toggles are placed so that their counted edge lands in the same cycle as a count load or a flag clear. This exercises the drop rule of R10 and the set-wins rule of R8.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_ovf,
  output logic       irq_edge
);
  localparam int OVF_BIT  = 5;
  localparam int EDGE_BIT = 4;

  logic [SYNC_STAGES-1:0] sync_q;
  logic       prev_q;
  logic [7:0] cnt_q;
  logic [2:0] ctrl_q;
  logic       ovf_q, edg_q, ovf_msk_q, edg_msk_q;

  wire pin_s  = sync_q[SYNC_STAGES-1];
  wire rise   = pin_s & ~prev_q;
  wire fall   = ~pin_s & prev_q;
  wire ev     = ctrl_q[0] & (ctrl_q[1] ? (rise | fall) : (ctrl_q[2] ? rise : fall));
  wire wr_cnt = wr && addr == 2'd0;
  wire ev_ok  = ev && !wr_cnt;
  wire wr_flg = wr && addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= pin_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= '0;
      ctrl_q    <= '0;
      ovf_q     <= 1'b0;
      edg_q     <= 1'b0;
      ovf_msk_q <= 1'b0;
      edg_msk_q <= 1'b0;
    end else begin
      if (wr_cnt)      cnt_q <= wdata;
      else if (ev_ok)  cnt_q <= cnt_q + 8'd1;
      if (wr && addr == 2'd1) ctrl_q <= wdata[2:0];
      if (wr && addr == 2'd3) begin
        ovf_msk_q <= wdata[OVF_BIT];
        edg_msk_q <= wdata[EDGE_BIT];
      end
      if (ev_ok && cnt_q == 8'hFF)              ovf_q <= 1'b1;
      else if (wr_flg && wdata[OVF_BIT])       ovf_q <= 1'b0;
      if (ev_ok)                               edg_q <= 1'b1;
      else if (wr_flg && wdata[EDGE_BIT])      edg_q <= 1'b0;
    end

  always_comb
    case (addr)
      2'd0:    rdata = cnt_q;
      2'd1:    rdata = {5'b0, ctrl_q};
      2'd2:    rdata = {2'b0, ovf_q, edg_q, 4'b0};
      default: rdata = {2'b0, ovf_msk_q, edg_msk_q, 4'b0};
    endcase

  assign irq_ovf  = ovf_q & ovf_msk_q;
  assign irq_edge = edg_q & edg_msk_q;
endmodule

module pulse_accum_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       ev,
  input logic       en,
  input logic [7:0] cnt,
  input logic       ovf,
  input logic       edg,
  input logic       ovf_msk,
  input logic       irq_ovf
);
  a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(wr && addr == 2'd0)) |=> $stable(cnt));
  a_r6_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !(wr && addr == 2'd0) && cnt == 8'hFF) |=> (ovf && cnt == 8'd0));
  a_r7_edge_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !(wr && addr == 2'd0)) |=> edg);
  a_r8_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd2 && wdata[5] && !(ev && cnt == 8'hFF)) |=> !ovf);
  a_r9_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_msk |-> !irq_ovf);
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0) |=> cnt == $past(wdata));
endmodule

bind pulse_accum pulse_accum_chk chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
  .ev(ev), .en(ctrl_q[0]), .cnt(cnt_q), .ovf(ovf_q), .edg(edg_q),
  .ovf_msk(ovf_msk_q), .irq_ovf(irq_ovf)
);

// File: tb/pulse_accum_test.sv
module pulse_accum_test;
  logic clk = 0, rst_n = 0, pin_in = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_ovf, irq_edge;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference state
  int m_cnt = 0, m_ctrl = 0, m_ovf = 0, m_edg = 0, m_movf = 0, m_medg = 0;
  int h1 = 0, h2 = 0, h3 = 0;

  pulse_accum uut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .addr(addr),
    .wr(wr), .wdata(wdata), .rdata(rdata), .irq_ovf(irq_ovf), .irq_edge(irq_edge));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      int rise, fall, ev;
      rise = (h2 == 1 && h3 == 0);
      fall = (h2 == 0 && h3 == 1);
      ev = (m_ctrl & 1) && (((m_ctrl >> 1) & 1) ? (rise || fall)
                                                 : (((m_ctrl >> 2) & 1) ? rise : fall));
      if (wr && addr == 0) begin
        m_cnt = wdata;
        ev = 0;                       // R10 dropped event
      end
      if (wr && addr == 1) m_ctrl = wdata & 7;
      if (wr && addr == 2) begin
        if (wdata[5]) m_ovf = 0;
        if (wdata[4]) m_edg = 0;
      end
      if (wr && addr == 3) begin
        m_movf = wdata[5];
        m_medg = wdata[4];
      end
      if (ev) begin
        if (m_cnt == 255) m_ovf = 1;  // R6
        m_cnt = (m_cnt + 1) % 256;
        m_edg = 1;                    // R7
      end
      h3 = h2; h2 = h1; h1 = pin_in;
    end
  end

  function automatic int exp_rdata();
    case (addr)
      0: return m_cnt;
      1: return m_ctrl;
      2: return (m_ovf << 5) | (m_edg << 4);
      default: return (m_movf << 5) | (m_medg << 4);
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, "rdata(R11)", rdata, exp_rdata());
    check(cur_req, "irq_ovf(R9)", irq_ovf, m_ovf & m_movf);
    check(cur_req, "irq_edge(R9)", irq_edge, m_edg & m_medg);
  end

  int cyc = 0;
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr = 0; addr = cyc[1:0]; cyc++;
    end
  endtask

  task automatic wreg(int a, int d);
    @(negedge clk); #1;
    wr = 1; addr = a[1:0]; wdata = d[7:0];
    @(negedge clk); #1;
    wr = 0;
  endtask

  task automatic toggles(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      pin_in = ~pin_in;
      idle(gap);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values before release
    check("R1", "rdata cnt", rdata, 0);
    check("R1", "irq_ovf", irq_ovf, 0);
    check("R1", "irq_edge", irq_edge, 0);
    rst_n = 1;
    cur_req = "R1"; idle(8);
    cur_req = "R3"; toggles(6, 4);              // disabled: nothing counts
    wreg(0, 0);
    cur_req = "R9"; wreg(3, 8'h30);
    cur_req = "R4"; wreg(1, 3'b101); toggles(8, 5);   // rising only
    wreg(2, 8'h30);
    cur_req = "R4"; wreg(1, 3'b001); toggles(8, 5);   // falling only
    // R2 exact latency: toggle then read count each cycle
    cur_req = "R2"; wreg(0, 10);
    @(negedge clk); #1; pin_in = ~pin_in; addr = 0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    cur_req = "R5"; wreg(1, 3'b011); toggles(10, 3);  // both edges
    wreg(1, 3'b111); toggles(6, 3);
    cur_req = "R6"; wreg(0, 8'hFD); toggles(6, 4);    // wrap
    cur_req = "R8"; wreg(2, 8'h10); idle(4); wreg(2, 8'h20); idle(4);
    // R10: load in every cycle around an edge
    cur_req = "R10";
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1; pin_in = ~pin_in;
      for (int j = 0; j < k + 1; j++) idle(1);
      wreg(0, 8'h40 + k);
      idle(4);
    end
    // R8: clear in same cycle as a set (set wins)
    cur_req = "R8";
    for (int k = 0; k < 4; k++) begin
      wreg(0, 8'hFF);
      @(negedge clk); #1; pin_in = ~pin_in;
      for (int j = 0; j < k; j++) idle(1);
      wreg(2, 8'h30);
      idle(4);
    end
    cur_req = "R9"; wreg(3, 8'h10); idle(4); wreg(3, 8'h20); idle(4); wreg(3, 0); idle(4);
    cur_req = "R3"; wreg(1, 3'b110); toggles(6, 3);
    cur_req = "R11"; wreg(1, 8'hFF); idle(8);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule